// File: doc/BRIEF.md
# Interrupt-Acknowledge Handler Sequencer

This block serves the seven interrupt request levels of a backplane bus, numbered 1 to 7. When a level is requested and software has enabled it, the sequencer asks for bus ownership and waits for the grant. It then runs one acknowledge cycle for that level and stores the returned status/ID byte in a register kept for that level. It then sets a done bit for the level. Local software reads each ID register through a level-addressed read port. It clears done and error bits by pulsing one-hot clear masks.

A level with a done or error bit still set takes no part in arbitration, so each acknowledged event is serviced once. Each level's status drives one of two local interrupt outputs, the normal one or the error one, selected per level by a routing mask. The acknowledge response is a simple stream. The sequencer holds `ack_active` and `ack_level` steady until a response beat (`resp_valid`) arrives. It accepts that beat on the same edge, so it is always ready while a cycle is open and never applies back-pressure. A response beat that arrives while no cycle is open is ignored.

Top module: `irqh_top`

## Requirements
- R1: A level is serviced only if its bit in `irq_req` and its bit in `lvl_enable` are both 1. Bit i stands for level i+1. When no level qualifies, `bus_req` stays 0.
- R2: When a level qualifies, `bus_req` rises one cycle later. `ack_active` stays 0 until `bus_grant` has been seen high while `bus_req` is asserted. `ack_active` then rises on the following cycle.
- R3: When several levels qualify, the highest-numbered one is acknowledged first. `ack_level` carries that level number (1..7) and holds it for the whole cycle.
- R4: A response beat without `resp_err` stores `resp_id` in the ID register of the acknowledged level. It also sets that level's bit in `done_status`. Both take effect on the edge that accepts the beat.
- R5: A level whose `done_status` or `err_status` bit is 1 is not acknowledged again until that bit is cleared.
- R6: A response beat with `resp_err` set sets that level's `err_status` bit. The level's ID register is left unchanged.
- R7: `bus_req` and `ack_active` drop on the edge that accepts the response beat. They are 0 in the following cycle.
- R8: `irq_norm` is the OR of (done|err) over the levels whose `route_err` bit is 0. `irq_err` is the same OR over the levels whose `route_err` bit is 1.
- R9: After reset all status bits, ID registers, `bus_req`, `ack_active` and both interrupt outputs are 0.
- R10: A 1 in `clr_done` or `clr_err` clears the matching status bit on the next edge. A set and a clear of the same bit on the same edge leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NLVL | Interrupt request per level, bit i = level i+1 |
| lvl_enable | input | NLVL | Handler enable per level |
| route_err | input | NLVL | 1 routes the level to `irq_err`, 0 to `irq_norm` |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| ack_active | output | 1 | Acknowledge cycle open (stream valid toward responder) |
| ack_level | output | LW | Level number being acknowledged |
| resp_valid | input | 1 | Response beat from the acknowledged slave |
| resp_err | input | 1 | Response beat ended in a bus error |
| resp_id | input | IDW | Returned status/ID |
| clr_done | input | NLVL | Clear mask for done bits |
| clr_err | input | NLVL | Clear mask for error bits |
| rd_level | input | LW | Level number whose ID is read |
| rd_id | output | IDW | ID register of `rd_level` (0 for an invalid level) |
| done_status | output | NLVL | Acknowledge completed per level |
| err_status | output | NLVL | Acknowledge ended in bus error per level |
| irq_norm | output | 1 | Normal local interrupt |
| irq_err | output | 1 | Error local interrupt |

## Verification
The bench uses the defaults: seven levels, an 8-bit ID and a 3-bit level number. With these values every level number from 1 to 7 and the unused code 0 appear on `ack_level` and `rd_level`. Random request, enable and routing masks reach all 128 patterns. Random grant and response delays, together with occasional bus errors and clears, create cases where a stale status bit masks a level, a masked level reappears after its clear, and an error leaves an earlier ID in place.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_ACK  = 2'd2
  } seq_st_t;
endpackage

// File: rtl/irqh_prio.sv
// Picks the highest-numbered pending level; output is the 1-based level number.
module irqh_prio #(
  parameter int N  = 7,
  parameter int LW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [LW-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) lvl = LW'(i + 1);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/irqh_seq.sv
// Request / grant / acknowledge sequencer.
module irqh_seq
  import irqh_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] start_lvl,
  input  logic          bus_grant,
  input  logic          resp_valid,
  output logic          bus_req,
  output logic          ack_active,
  output logic [LW-1:0] ack_level,
  output logic          fin
);
  seq_st_t       st_q, st_d;
  logic [LW-1:0] lvl_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (start)      st_d = SEQ_REQ;
      SEQ_REQ:  if (bus_grant)  st_d = SEQ_ACK;
      SEQ_ACK:  if (resp_valid) st_d = SEQ_IDLE;
      default:                  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      lvl_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == SEQ_IDLE && start) lvl_q <= start_lvl;
    end
  end

  assign bus_req    = (st_q != SEQ_IDLE);
  assign ack_active = (st_q == SEQ_ACK);
  assign ack_level  = lvl_q;
  assign fin        = ack_active && resp_valid;
endmodule

// File: rtl/irqh_bank.sv
// Per-level ID registers, status bits, read mux and interrupt routing.
module irqh_bank #(
  parameter int N   = 7,
  parameter int IDW = 8,
  parameter int LW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fin,
  input  logic           fin_err,
  input  logic [LW-1:0]  fin_lvl,
  input  logic [IDW-1:0] resp_id,
  input  logic [N-1:0]   clr_done,
  input  logic [N-1:0]   clr_err,
  input  logic [N-1:0]   route_err,
  input  logic [LW-1:0]  rd_level,
  output logic [IDW-1:0] rd_id,
  output logic [N-1:0]   done_status,
  output logic [N-1:0]   err_status,
  output logic           irq_norm,
  output logic           irq_err
);
  logic [IDW-1:0] id_q [N];
  logic [N-1:0]   flag;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    logic hit;
    assign hit = fin && (fin_lvl == LW'(g + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_q[g]        <= '0;
        done_status[g] <= 1'b0;
        err_status[g]  <= 1'b0;
      end else begin
        if (hit && !fin_err) begin
          id_q[g]        <= resp_id;
          done_status[g] <= 1'b1;
        end else if (clr_done[g]) begin
          done_status[g] <= 1'b0;
        end
        if (hit && fin_err)   err_status[g] <= 1'b1;
        else if (clr_err[g])  err_status[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_id = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_level == LW'(i + 1)) rd_id = id_q[i];
    end
  end

  assign flag     = done_status | err_status;
  assign irq_norm = |(flag & ~route_err);
  assign irq_err  = |(flag & route_err);
endmodule

// File: rtl/irqh_top.sv
module irqh_top #(
  parameter int NLVL = 7,
  parameter int IDW  = 8,
  parameter int LW   = $clog2(NLVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_req,
  input  logic [NLVL-1:0] lvl_enable,
  input  logic [NLVL-1:0] route_err,
  output logic            bus_req,
  input  logic            bus_grant,
  output logic            ack_active,
  output logic [LW-1:0]   ack_level,
  input  logic            resp_valid,
  input  logic            resp_err,
  input  logic [IDW-1:0]  resp_id,
  input  logic [NLVL-1:0] clr_done,
  input  logic [NLVL-1:0] clr_err,
  input  logic [LW-1:0]   rd_level,
  output logic [IDW-1:0]  rd_id,
  output logic [NLVL-1:0] done_status,
  output logic [NLVL-1:0] err_status,
  output logic            irq_norm,
  output logic            irq_err
);
  logic [NLVL-1:0] pend;
  logic            pend_any;
  logic [LW-1:0]   pend_lvl;
  logic            fin;

  assign pend = irq_req & lvl_enable & ~done_status & ~err_status;

  irqh_prio #(.N(NLVL), .LW(LW)) u_prio (
    .pend (pend),
    .any  (pend_any),
    .lvl  (pend_lvl)
  );

  irqh_seq #(.LW(LW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (pend_any),
    .start_lvl  (pend_lvl),
    .bus_grant  (bus_grant),
    .resp_valid (resp_valid),
    .bus_req    (bus_req),
    .ack_active (ack_active),
    .ack_level  (ack_level),
    .fin        (fin)
  );

  irqh_bank #(.N(NLVL), .IDW(IDW), .LW(LW)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .fin         (fin),
    .fin_err     (resp_err),
    .fin_lvl     (ack_level),
    .resp_id     (resp_id),
    .clr_done    (clr_done),
    .clr_err     (clr_err),
    .route_err   (route_err),
    .rd_level    (rd_level),
    .rd_id       (rd_id),
    .done_status (done_status),
    .err_status  (err_status),
    .irq_norm    (irq_norm),
    .irq_err     (irq_err)
  );
endmodule

// File: rtl/irqh_chk.sv
module irqh_chk #(
  parameter int N  = 7,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          ack_active,
  input logic [LW-1:0] ack_level,
  input logic          resp_valid,
  input logic          resp_err,
  input logic [N-1:0]  done_status,
  input logic [N-1:0]  err_status
);
  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_active |-> bus_req);

  // R2
  ack_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_active) |-> ($past(bus_grant) && $past(bus_req)));

  // R3
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_active |-> (ack_level != '0 && int'(ack_level) <= N));

  // R3
  level_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_active && !resp_valid) |=> (ack_active && $stable(ack_level)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_active && resp_valid) |=> (!bus_req && !ack_active));

  // R5
  no_reack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_active) |-> !(done_status[ack_level - 1'b1] || err_status[ack_level - 1'b1]));

  // R6
  err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_active && resp_valid && resp_err) |=> ((err_status & ~$past(err_status)) != '0));
endmodule

bind irqh_top irqh_chk #(.N(NLVL), .LW(LW)) u_chk (.*);

// File: tb/sim_irqh_top.sv
module sim_irqh_top;
  localparam int N = 7, IDW = 8, LW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_req, bus_grant, ack_active, resp_valid, resp_err, irq_norm, irq_err;
  logic [N-1:0] irq_req, lvl_enable, route_err, clr_done, clr_err, done_status, err_status;
  logic [LW-1:0] ack_level, rd_level;
  logic [IDW-1:0] resp_id, rd_id;

  irqh_top #(.NLVL(N), .IDW(IDW)) u0 (.*);

  logic [N-1:0] m_done, m_err;
  logic [IDW-1:0] m_id [N];
  int checks = 0, fails = 0;
  bit over = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int top_lvl(input logic [N-1:0] p);
    int r = 0;
    for (int i = 0; i < N; i++) if (p[i]) r = i + 1;
    return r;
  endfunction

  function automatic logic exp_irq(input bit to_err);
    logic [N-1:0] f = m_done | m_err;
    return to_err ? |(f & route_err) : |(f & ~route_err);
  endfunction

  task automatic check_all();
    for (int i = 0; i < N; i++) begin
      rd_level = LW'(i + 1);
      #1;
      chk(rd_id == m_id[i], "R4/R6 id register", rd_id, m_id[i]);
    end
    rd_level = '0;
    #1;
    chk(rd_id == '0, "R4 invalid read level", rd_id, 0);
    chk(done_status == m_done, "R4/R10 done_status", done_status, m_done);
    chk(err_status == m_err, "R6/R10 err_status", err_status, m_err);
    chk(irq_norm == exp_irq(0), "R8 irq_norm", irq_norm, exp_irq(0));
    chk(irq_err == exp_irq(1), "R8 irq_err", irq_err, exp_irq(1));
  endtask

  task automatic run_seq(input logic [N-1:0] irq, input logic [N-1:0] en, input bit err,
                         input logic [IDW-1:0] id, input int gdly, input int rdly);
    int lv;
    irq_req = irq;
    lvl_enable = en;
    lv = top_lvl(irq & en & ~m_done & ~m_err);
    if (lv == 0) begin
      repeat (3) begin
        @(negedge clk);
        chk(!bus_req && !ack_active, "R1/R5 no service", bus_req, 0);
      end
      irq_req = '0;
      return;
    end
    @(negedge clk);
    chk(bus_req, "R2 request raised", bus_req, 1);
    chk(!ack_active, "R2 no ack before grant", ack_active, 0);
    // a stray response outside a cycle must not change anything
    resp_valid = 1'b1; resp_id = ~id; resp_err = 1'b0;
    repeat (gdly) begin
      @(negedge clk);
      chk(bus_req && !ack_active, "R2 waiting for grant", ack_active, 0);
    end
    resp_valid = 1'b0;
    bus_grant = 1'b1;
    @(negedge clk);
    chk(ack_active, "R2 ack after grant", ack_active, 1);
    chk(ack_level == LW'(lv), "R3 acknowledged level", ack_level, lv);
    repeat (rdly) begin
      @(negedge clk);
      chk(ack_active && ack_level == LW'(lv), "R3 level held", ack_level, lv);
    end
    resp_valid = 1'b1; resp_err = err; resp_id = id;
    @(negedge clk);
    resp_valid = 1'b0; resp_err = 1'b0; bus_grant = 1'b0; irq_req = '0;
    chk(!bus_req && !ack_active, "R7 bus released", bus_req, 0);
    if (err) m_err[lv-1] = 1'b1;
    else begin
      m_done[lv-1] = 1'b1;
      m_id[lv-1] = id;
    end
    check_all();
  endtask

  task automatic do_clear(input logic [N-1:0] cd, input logic [N-1:0] ce);
    clr_done = cd; clr_err = ce;
    @(negedge clk);
    clr_done = '0; clr_err = '0;
    m_done &= ~cd;
    m_err &= ~ce;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; irq_req = '0; lvl_enable = '0; route_err = '0; bus_grant = 1'b0;
    resp_valid = 1'b0; resp_err = 1'b0; resp_id = '0; clr_done = '0; clr_err = '0; rd_level = '0;
    m_done = '0; m_err = '0;
    for (int i = 0; i < N; i++) m_id[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk(!bus_req && !ack_active, "R9 reset bus outputs", bus_req, 0);
    chk(!irq_norm && !irq_err, "R9 reset interrupts", irq_norm, 0);
    check_all();

    // R3 all pending: 7, then 6, then 5
    run_seq(7'h7F, 7'h7F, 0, 8'h71, 0, 0);
    run_seq(7'h7F, 7'h7F, 0, 8'h62, 1, 2);
    run_seq(7'h7F, 7'h7F, 1, 8'h53, 2, 0);
    // R1 disabled level ignored
    run_seq(7'h08, 7'h77, 0, 8'hAA, 0, 0);
    // R5 level 7 still done: not re-acknowledged
    run_seq(7'h40, 7'h7F, 0, 8'hBB, 0, 0);
    // R10 / R6 level 7 after clear: error keeps old ID
    do_clear(7'h40, 7'h10);
    run_seq(7'h40, 7'h7F, 1, 8'hCC, 0, 1);
    // R8 routing
    route_err = 7'h55;
    #1;
    check_all();
    do_clear(7'h7F, 7'h7F);

    for (int it = 0; it < 200; it++) begin
      if ($urandom % 4 == 0) route_err = N'($urandom);
      run_seq(N'($urandom), N'($urandom), ($urandom % 5) == 0, IDW'($urandom),
              int'($urandom % 4), int'($urandom % 3));
      if ($urandom % 3 == 0) do_clear(N'($urandom), N'($urandom));
    end

    over = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule